// File: doc/BRIEF.md
# Integrity Tree Walk Controller

This block checks one counter from external memory against an on-chip root by walking a counter-based integrity tree, one level at a time. A walk request carries a cache-line index and a tree depth. The controller reads the leaf counter block that covers the line. It then reads each ancestor node in turn. After each ancestor arrives, it hands the child node and that parent node to an external MAC-check unit and waits for the verdict. Each level is read only after the level below it has been verified.

When the top fetched node has passed its check, it is compared bit for bit with the root value held in an on-chip register. The root itself is never read from memory. A full match raises a one-cycle pass pulse. A failed MAC check or a root mismatch stops the walk at once and raises a sticky fault that carries a cause and a level. The fault holds until the fault-clear input is asserted. Only one walk is in flight at a time.

Top module: `itree_walker`

## Requirements
- R1: While reset is asserted and after it is released, `walk_ready_o` is 1 and `rd_valid_o`, `mac_valid_o`, `pass_o` and `fault_o` are 0, with `fault_code_o` equal to 0.
- R2: The node read for level k (k = 0 is the leaf block) goes to address `lvl_base_i[k*AW +: AW] + (line >> 3*(k+1))`. Reads are issued in the order k = 0, 1, 2, ..., with exactly one read per level.
- R3: The walk is strictly sequential. No read is issued while an earlier read is unanswered or while a MAC check is outstanding. The MAC checks are issued for parent levels 1, 2, ... in order.
- R4: The MAC request for parent level k carries `mac_child_o` = the data read at level k-1, `mac_parent_o` = the data read at level k, and `mac_level_o` = k.
- R5: With depth D, a walk in which every check passes makes exactly D reads and D-1 MAC checks. It compares the level D-1 node with `root_i` and, on equality, raises `pass_o` for exactly one cycle before `walk_ready_o` returns to 1.
- R6: A failed MAC response for parent level k ends the walk with `fault_o` = 1, `fault_code_o` = 1 and `fault_level_o` = k. No further read is issued and `pass_o` is not raised.
- R7: If the level D-1 node differs from `root_i`, the walk ends with `fault_o` = 1, `fault_code_o` = 2 and `fault_level_o` = D.
- R8: A fault is sticky. It holds its code and level, keeps `walk_ready_o` at 0 and issues no read or MAC request until `fault_clr_i` is asserted. One cycle after the clear, the block is idle with `walk_ready_o` = 1 and `fault_code_o` = 0.
- R9: From the cycle a request is accepted until the walk ends, `walk_ready_o` is 0, and any `walk_valid_i` during the walk has no effect on the addresses read.
- R10: A requested depth of 0 is treated as 1, and a depth above MAX_LEVELS (6 by default) is treated as MAX_LEVELS.
- R11: A read or MAC request that is not accepted stays asserted in the next cycle with unchanged address or payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| walk_valid_i | input | 1 | Walk request valid |
| walk_ready_o | output | 1 | Ready for a walk request (idle) |
| walk_line_i | input | AW | Cache-line index to verify |
| walk_depth_i | input | $clog2(MAX_LEVELS+1) | Number of fetched tree levels |
| lvl_base_i | input | MAX_LEVELS*AW | Per-level node base addresses, level k at bits k*AW |
| root_i | input | NODE_W | On-chip root value |
| rd_valid_o | output | 1 | Node read request valid |
| rd_ready_i | input | 1 | Node read request accepted |
| rd_addr_o | output | AW | Node read address |
| rd_rsp_valid_i | input | 1 | Node read data valid |
| rd_rsp_data_i | input | NODE_W | Node read data |
| mac_valid_o | output | 1 | MAC check request valid |
| mac_ready_i | input | 1 | MAC check request accepted |
| mac_child_o | output | NODE_W | Child node for the check |
| mac_parent_o | output | NODE_W | Parent node for the check |
| mac_level_o | output | $clog2(MAX_LEVELS+1) | Parent level of the check |
| mac_rsp_valid_i | input | 1 | MAC verdict valid |
| mac_rsp_ok_i | input | 1 | MAC verdict: 1 match, 0 mismatch |
| fault_clr_i | input | 1 | Clears a sticky fault |
| pass_o | output | 1 | One-cycle pulse: walk verified |
| fault_o | output | 1 | Sticky fault flag |
| fault_code_o | output | 2 | 1 MAC mismatch, 2 root mismatch, 0 none |
| fault_level_o | output | $clog2(MAX_LEVELS+1) | Level whose check failed |

## Verification
The assertions check, on every cycle, the ordering rules of the walk. A read is never issued while a read or a MAC check is outstanding, and requests that are not accepted hold steady. A fault stays latched with frozen code and level and suppresses all requests. Ready drops right after a request is accepted, and the pass pulse lasts one cycle and never coincides with a fault. The bench scenarios show what depends on data: the per-level address arithmetic, the child and parent values handed to the MAC unit, the depth clamp, and the exact read count and fault level for a MAC failure at each level or a root mismatch.

// File: rtl/itw_pkg.sv
package itw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FETCH    = 3'd1,
    ST_WAIT_MEM = 3'd2,
    ST_CHECK    = 3'd3,
    ST_WAIT_MAC = 3'd4,
    ST_ROOT_CMP = 3'd5,
    ST_DONE_OK  = 3'd6,
    ST_FAULT    = 3'd7
  } walk_state_e;

  localparam logic [1:0] FC_NONE = 2'd0;
  localparam logic [1:0] FC_MAC  = 2'd1;
  localparam logic [1:0] FC_ROOT = 2'd2;

endpackage

// File: rtl/itw_addr_gen.sv
module itw_addr_gen #(
  parameter int MAX_LEVELS = 6,
  parameter int AW         = 32,
  parameter int ARITY_LOG2 = 3,
  parameter int LVL_W      = 3
) (
  input  logic [AW-1:0]            line_i,
  input  logic [LVL_W-1:0]         level_i,
  input  logic [MAX_LEVELS*AW-1:0] base_i,
  output logic [AW-1:0]            addr_o
);

  logic [AW-1:0] cand [MAX_LEVELS];

  // One candidate address per level; the shift is a constant per level.
  for (genvar g = 0; g < MAX_LEVELS; g++) begin : g_lvl
    localparam int SHIFT = ARITY_LOG2 * (g + 1);
    assign cand[g] = base_i[g*AW +: AW] + (line_i >> SHIFT);
  end

  always_comb begin
    addr_o = cand[0];
    for (int i = 1; i < MAX_LEVELS; i++) begin
      if (level_i == LVL_W'(i)) addr_o = cand[i];
    end
  end

endmodule

// File: rtl/itw_node_buf.sv
module itw_node_buf #(
  parameter int NODE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [NODE_W-1:0] data_i,
  output logic [NODE_W-1:0] child_o,
  output logic [NODE_W-1:0] parent_o
);

  logic [NODE_W-1:0] child_q;
  logic [NODE_W-1:0] parent_q;

  // The newest node becomes the parent; the previous one moves down to child.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      child_q  <= '0;
      parent_q <= '0;
    end else if (shift_en) begin
      child_q  <= parent_q;
      parent_q <= data_i;
    end
  end

  assign child_o  = child_q;
  assign parent_o = parent_q;

endmodule

// File: rtl/itw_ctrl.sv
module itw_ctrl
  import itw_pkg::*;
#(
  parameter int MAX_LEVELS = 6,
  parameter int AW         = 32,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [AW-1:0]    req_line_i,
  input  logic [LVL_W-1:0] req_depth_i,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  input  logic             rd_rsp_valid_i,
  output logic             mac_valid_o,
  input  logic             mac_ready_i,
  input  logic             mac_rsp_valid_i,
  input  logic             mac_rsp_ok_i,
  input  logic             root_match_i,
  input  logic             fault_clr_i,
  output logic [AW-1:0]    line_o,
  output logic [LVL_W-1:0] level_o,
  output logic             node_shift_o,
  output logic             pass_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [LVL_W-1:0] fault_level_o
);

  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_LEVELS);

  walk_state_e      state_q, state_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             level_en;
  logic [LVL_W-1:0] depth_q, depth_clamped;
  logic [AW-1:0]    line_q;
  logic             load_en;
  logic [1:0]       fcode_q, fcode_d;
  logic [LVL_W-1:0] flevel_q, flevel_d;
  logic             fault_en;
  logic [LVL_W-1:0] top_lvl;

  // Requested depth clamped into 1..MAX_LEVELS.
  always_comb begin
    depth_clamped = req_depth_i;
    if (req_depth_i == '0)          depth_clamped = LVL_ONE;
    else if (req_depth_i > LVL_MAX) depth_clamped = LVL_MAX;
  end

  assign top_lvl = depth_q - LVL_ONE;

  // Next-state logic.
  always_comb begin
    state_d      = state_q;
    level_en     = 1'b0;
    level_d      = level_q;
    load_en      = 1'b0;
    node_shift_o = 1'b0;
    fault_en     = 1'b0;
    fcode_d      = fcode_q;
    flevel_d     = flevel_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          load_en  = 1'b1;
          level_en = 1'b1;
          level_d  = '0;
          state_d  = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (rd_ready_i) state_d = ST_WAIT_MEM;
      end
      ST_WAIT_MEM: begin
        if (rd_rsp_valid_i) begin
          node_shift_o = 1'b1;
          if (level_q != '0) begin
            state_d = ST_CHECK;
          end else if (top_lvl == '0) begin
            state_d = ST_ROOT_CMP;
          end else begin
            level_en = 1'b1;
            level_d  = LVL_ONE;
            state_d  = ST_FETCH;
          end
        end
      end
      ST_CHECK: begin
        if (mac_ready_i) state_d = ST_WAIT_MAC;
      end
      ST_WAIT_MAC: begin
        if (mac_rsp_valid_i) begin
          if (!mac_rsp_ok_i) begin
            fault_en = 1'b1;
            fcode_d  = FC_MAC;
            flevel_d = level_q;
            state_d  = ST_FAULT;
          end else if (level_q == top_lvl) begin
            state_d = ST_ROOT_CMP;
          end else begin
            level_en = 1'b1;
            level_d  = level_q + LVL_ONE;
            state_d  = ST_FETCH;
          end
        end
      end
      ST_ROOT_CMP: begin
        if (root_match_i) begin
          state_d = ST_DONE_OK;
        end else begin
          fault_en = 1'b1;
          fcode_d  = FC_ROOT;
          flevel_d = depth_q;
          state_d  = ST_FAULT;
        end
      end
      ST_DONE_OK: begin
        state_d = ST_IDLE;
      end
      ST_FAULT: begin
        if (fault_clr_i) begin
          fault_en = 1'b1;
          fcode_d  = FC_NONE;
          flevel_d = '0;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= LVL_ONE;
      line_q  <= '0;
    end else if (load_en) begin
      depth_q <= depth_clamped;
      line_q  <= req_line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcode_q  <= FC_NONE;
      flevel_q <= '0;
    end else if (fault_en) begin
      fcode_q  <= fcode_d;
      flevel_q <= flevel_d;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign rd_valid_o    = (state_q == ST_FETCH);
  assign mac_valid_o   = (state_q == ST_CHECK);
  assign pass_o        = (state_q == ST_DONE_OK);
  assign fault_o       = (state_q == ST_FAULT);
  assign fault_code_o  = fcode_q;
  assign fault_level_o = flevel_q;
  assign line_o        = line_q;
  assign level_o       = level_q;

endmodule

// File: rtl/itree_walker.sv
module itree_walker #(
  parameter int MAX_LEVELS = 6,
  parameter int AW         = 32,
  parameter int NODE_W     = 64,
  parameter int ARITY_LOG2 = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              walk_valid_i,
  output logic                              walk_ready_o,
  input  logic [AW-1:0]                     walk_line_i,
  input  logic [$clog2(MAX_LEVELS+1)-1:0]   walk_depth_i,
  input  logic [MAX_LEVELS*AW-1:0]          lvl_base_i,
  input  logic [NODE_W-1:0]                 root_i,
  output logic                              rd_valid_o,
  input  logic                              rd_ready_i,
  output logic [AW-1:0]                     rd_addr_o,
  input  logic                              rd_rsp_valid_i,
  input  logic [NODE_W-1:0]                 rd_rsp_data_i,
  output logic                              mac_valid_o,
  input  logic                              mac_ready_i,
  output logic [NODE_W-1:0]                 mac_child_o,
  output logic [NODE_W-1:0]                 mac_parent_o,
  output logic [$clog2(MAX_LEVELS+1)-1:0]   mac_level_o,
  input  logic                              mac_rsp_valid_i,
  input  logic                              mac_rsp_ok_i,
  input  logic                              fault_clr_i,
  output logic                              pass_o,
  output logic                              fault_o,
  output logic [1:0]                        fault_code_o,
  output logic [$clog2(MAX_LEVELS+1)-1:0]   fault_level_o
);

  localparam int LVL_W = $clog2(MAX_LEVELS + 1);

  logic [AW-1:0]     line_q;
  logic [LVL_W-1:0]  level_q;
  logic              node_shift;
  logic [NODE_W-1:0] child_node;
  logic [NODE_W-1:0] parent_node;
  logic              root_match;

  assign root_match = (parent_node == root_i);

  itw_ctrl #(
    .MAX_LEVELS(MAX_LEVELS),
    .AW        (AW),
    .LVL_W     (LVL_W)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (walk_valid_i),
    .req_ready_o    (walk_ready_o),
    .req_line_i     (walk_line_i),
    .req_depth_i    (walk_depth_i),
    .rd_valid_o     (rd_valid_o),
    .rd_ready_i     (rd_ready_i),
    .rd_rsp_valid_i (rd_rsp_valid_i),
    .mac_valid_o    (mac_valid_o),
    .mac_ready_i    (mac_ready_i),
    .mac_rsp_valid_i(mac_rsp_valid_i),
    .mac_rsp_ok_i   (mac_rsp_ok_i),
    .root_match_i   (root_match),
    .fault_clr_i    (fault_clr_i),
    .line_o         (line_q),
    .level_o        (level_q),
    .node_shift_o   (node_shift),
    .pass_o         (pass_o),
    .fault_o        (fault_o),
    .fault_code_o   (fault_code_o),
    .fault_level_o  (fault_level_o)
  );

  itw_addr_gen #(
    .MAX_LEVELS(MAX_LEVELS),
    .AW        (AW),
    .ARITY_LOG2(ARITY_LOG2),
    .LVL_W     (LVL_W)
  ) u_addr (
    .line_i (line_q),
    .level_i(level_q),
    .base_i (lvl_base_i),
    .addr_o (rd_addr_o)
  );

  itw_node_buf #(
    .NODE_W(NODE_W)
  ) u_nodes (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(node_shift),
    .data_i  (rd_rsp_data_i),
    .child_o (child_node),
    .parent_o(parent_node)
  );

  assign mac_child_o  = child_node;
  assign mac_parent_o = parent_node;
  assign mac_level_o  = level_q;

endmodule

// File: rtl/itw_chk.sv
module itw_chk #(
  parameter int AW     = 32,
  parameter int NODE_W = 64,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              walk_valid_i,
  input logic              walk_ready_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [AW-1:0]     rd_addr_o,
  input logic              rd_rsp_valid_i,
  input logic              mac_valid_o,
  input logic              mac_ready_i,
  input logic [NODE_W-1:0] mac_child_o,
  input logic [NODE_W-1:0] mac_parent_o,
  input logic [LVL_W-1:0]  mac_level_o,
  input logic              mac_rsp_valid_i,
  input logic              fault_clr_i,
  input logic              pass_o,
  input logic              fault_o,
  input logic [1:0]        fault_code_o,
  input logic [LVL_W-1:0]  fault_level_o
);

  logic rd_outst_q;
  logic mac_outst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_outst_q <= 1'b0;
    end else if (rd_valid_o && rd_ready_i) begin
      rd_outst_q <= 1'b1;
    end else if (rd_rsp_valid_i) begin
      rd_outst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_outst_q <= 1'b0;
    end else if (mac_valid_o && mac_ready_i) begin
      mac_outst_q <= 1'b1;
    end else if (mac_rsp_valid_i) begin
      mac_outst_q <= 1'b0;
    end
  end

  // R3
  rd_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !rd_outst_q);

  // R3
  rd_after_mac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> !mac_outst_q);

  // R3
  mac_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid_o |-> !mac_outst_q && !rd_outst_q);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_addr_o));

  // R11
  mac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mac_valid_o && !mac_ready_i |=> mac_valid_o && $stable(mac_child_o)
      && $stable(mac_parent_o) && $stable(mac_level_o));

  // R8
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !fault_clr_i |=> fault_o && $stable(fault_code_o) && $stable(fault_level_o));

  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !walk_ready_o && !rd_valid_o && !mac_valid_o);

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid_i && walk_ready_o |=> !walk_ready_o);

  // R5
  pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |=> !pass_o && walk_ready_o);

  // R6
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> !fault_o);

endmodule

bind itree_walker itw_chk #(
  .AW    (AW),
  .NODE_W(NODE_W),
  .LVL_W ($clog2(MAX_LEVELS + 1))
) u_itw_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .walk_valid_i   (walk_valid_i),
  .walk_ready_o   (walk_ready_o),
  .rd_valid_o     (rd_valid_o),
  .rd_ready_i     (rd_ready_i),
  .rd_addr_o      (rd_addr_o),
  .rd_rsp_valid_i (rd_rsp_valid_i),
  .mac_valid_o    (mac_valid_o),
  .mac_ready_i    (mac_ready_i),
  .mac_child_o    (mac_child_o),
  .mac_parent_o   (mac_parent_o),
  .mac_level_o    (mac_level_o),
  .mac_rsp_valid_i(mac_rsp_valid_i),
  .fault_clr_i    (fault_clr_i),
  .pass_o         (pass_o),
  .fault_o        (fault_o),
  .fault_code_o   (fault_code_o),
  .fault_level_o  (fault_level_o)
);

// File: tb/test_itree_walker.sv
module test_itree_walker;

  localparam int CLK_PERIOD = 10;
  localparam int MAXL       = 6;
  localparam int AW         = 32;
  localparam int NW         = 64;
  localparam int LW         = 3;
  localparam int WATCHDOG   = 150000;

  logic          clk;
  logic          rst_n;
  logic          walk_valid_i;
  logic          walk_ready_o;
  logic [AW-1:0] walk_line_i;
  logic [LW-1:0] walk_depth_i;
  logic [MAXL*AW-1:0] lvl_base_i;
  logic [NW-1:0] root_i;
  logic          rd_valid_o;
  logic          rd_ready_i;
  logic [AW-1:0] rd_addr_o;
  logic          rd_rsp_valid_i;
  logic [NW-1:0] rd_rsp_data_i;
  logic          mac_valid_o;
  logic          mac_ready_i;
  logic [NW-1:0] mac_child_o;
  logic [NW-1:0] mac_parent_o;
  logic [LW-1:0] mac_level_o;
  logic          mac_rsp_valid_i;
  logic          mac_rsp_ok_i;
  logic          fault_clr_i;
  logic          pass_o;
  logic          fault_o;
  logic [1:0]    fault_code_o;
  logic [LW-1:0] fault_level_o;

  int checks;
  int fails;

  logic [AW-1:0] base_tab [MAXL];
  logic [AW-1:0] log_addr [16];
  int            log_n;
  int            mac_n;
  logic [AW-1:0] cur_line;
  int            cur_bad;
  int            m_busy, m_lat;
  logic [AW-1:0] m_addr;
  int            c_busy, c_lat;
  logic          c_ok;

  itree_walker i_itree_walker (
    .clk(clk), .rst_n(rst_n),
    .walk_valid_i(walk_valid_i), .walk_ready_o(walk_ready_o),
    .walk_line_i(walk_line_i), .walk_depth_i(walk_depth_i),
    .lvl_base_i(lvl_base_i), .root_i(root_i),
    .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o),
    .rd_rsp_valid_i(rd_rsp_valid_i), .rd_rsp_data_i(rd_rsp_data_i),
    .mac_valid_o(mac_valid_o), .mac_ready_i(mac_ready_i),
    .mac_child_o(mac_child_o), .mac_parent_o(mac_parent_o), .mac_level_o(mac_level_o),
    .mac_rsp_valid_i(mac_rsp_valid_i), .mac_rsp_ok_i(mac_rsp_ok_i),
    .fault_clr_i(fault_clr_i), .pass_o(pass_o), .fault_o(fault_o),
    .fault_code_o(fault_code_o), .fault_level_o(fault_level_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NW-1:0] node_val(input logic [AW-1:0] a);
    return {a ^ 32'h5A3C_96E1, ~a + 32'd17};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] line, input int k);
    return base_tab[k] + (line >> (3 * (k + 1)));
  endfunction

  function automatic int eff_depth(input int d);
    if (d == 0) return 1;
    if (d > MAXL) return MAXL;
    return d;
  endfunction

  // Memory model: random ready, random latency, logs every accepted address.
  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ready_i = 1'b0;
      rd_rsp_valid_i = 1'b0;
      rd_rsp_data_i = '0;
      m_busy = 0;
      m_lat = 0;
    end else begin
      rd_rsp_valid_i = 1'b0;
      if (m_busy != 0) begin
        m_lat--;
        if (m_lat == 0) begin
          rd_rsp_valid_i = 1'b1;
          rd_rsp_data_i = node_val(m_addr);
          m_busy = 0;
        end
      end
      rd_ready_i = ($urandom_range(3) != 0);
      if (rd_valid_o && rd_ready_i) begin
        // R3: no read may be issued while another is unanswered
        chk(m_busy == 0, "R3 read overlap", m_busy, 0);
        if (log_n < 16) log_addr[log_n] = rd_addr_o;
        log_n++;
        m_addr = rd_addr_o;
        m_busy = 1;
        m_lat = $urandom_range(3, 1);
      end
    end
  end

  // MAC model: checks the payload, fails at the chosen level.
  always @(negedge clk) begin
    if (!rst_n) begin
      mac_ready_i = 1'b0;
      mac_rsp_valid_i = 1'b0;
      mac_rsp_ok_i = 1'b0;
      c_busy = 0;
      c_lat = 0;
      c_ok = 1'b0;
    end else begin
      mac_rsp_valid_i = 1'b0;
      if (c_busy != 0) begin
        c_lat--;
        if (c_lat == 0) begin
          mac_rsp_valid_i = 1'b1;
          mac_rsp_ok_i = c_ok;
          c_busy = 0;
        end
      end
      mac_ready_i = ($urandom_range(2) != 0);
      if (mac_valid_o && mac_ready_i) begin
        int k;
        k = int'(mac_level_o);
        mac_n++;
        // R3: checks arrive for levels 1,2,... in order
        chk(k == mac_n, "R3 mac level order", k, mac_n);
        if (k >= 1 && k < MAXL) begin
          // R4: child and parent payload
          chk(mac_child_o == node_val(exp_addr(cur_line, k - 1)), "R4 mac child",
              mac_child_o, node_val(exp_addr(cur_line, k - 1)));
          chk(mac_parent_o == node_val(exp_addr(cur_line, k)), "R4 mac parent",
              mac_parent_o, node_val(exp_addr(cur_line, k)));
        end
        c_ok = (k != cur_bad);
        c_busy = 1;
        c_lat = $urandom_range(2, 1);
      end
    end
  end

  // bad = 0: clean walk; 1..De-1: MAC fails at that parent level; De: root mismatch.
  task automatic run_walk(input logic [AW-1:0] line, input int depth, input int bad);
    int de;
    int cyc;
    bit seen_pass;
    bit seen_fault;
    bit ready_err;
    int exp_reads;
    int exp_macs;
    int n0;
    de = eff_depth(depth);
    @(negedge clk);
    cur_line = line;
    cur_bad = bad;
    log_n = 0;
    mac_n = 0;
    root_i = node_val(exp_addr(line, de - 1)) ^ ((bad == de) ? 64'h1 : 64'h0);
    chk(walk_ready_o == 1'b1, "R9 ready before walk", walk_ready_o, 1);
    walk_valid_i = 1'b1;
    walk_line_i = line;
    walk_depth_i = LW'(depth);
    seen_pass = 0;
    seen_fault = 0;
    ready_err = 0;
    cyc = 0;
    while (!seen_pass && !seen_fault && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (pass_o) seen_pass = 1;
      if (fault_o) seen_fault = 1;
      if (seen_pass || seen_fault) begin
        walk_valid_i = 1'b0;
      end else begin
        if (walk_ready_o) ready_err = 1;
        // R9: extra requests during the walk must be ignored
        walk_valid_i = 1'b1;
        walk_line_i = $urandom;
        walk_depth_i = LW'($urandom_range(7));
      end
    end
    chk(!ready_err, "R9 ready low while busy", ready_err, 0);
    chk(cyc < 3000, "walk timeout", cyc, 3000);
    if (bad == 0) begin
      exp_reads = de; exp_macs = de - 1;
      chk(seen_pass && !seen_fault, "R5 pass outcome", {seen_pass, seen_fault}, 2'b10);
    end else if (bad < de) begin
      exp_reads = bad + 1; exp_macs = bad;
      chk(seen_fault && fault_code_o == 2'd1, "R6 mac fault code", fault_code_o, 1);
      chk(fault_level_o == LW'(bad), "R6 mac fault level", fault_level_o, bad);
    end else begin
      exp_reads = de; exp_macs = de - 1;
      chk(seen_fault && fault_code_o == 2'd2, "R7 root fault code", fault_code_o, 2);
      chk(fault_level_o == LW'(de), "R7 root fault level", fault_level_o, de);
    end
    // R2 / R10: read count follows the clamped depth
    chk(log_n == exp_reads, "R2 R10 read count", log_n, exp_reads);
    chk(mac_n == exp_macs, "R5 mac count", mac_n, exp_macs);
    for (int k = 0; k < exp_reads && k < 16; k++) begin
      chk(log_addr[k] == exp_addr(line, k), "R2 read address", log_addr[k], exp_addr(line, k));
    end
    if (seen_pass) begin
      @(negedge clk);
      chk(!pass_o && walk_ready_o, "R5 pass one cycle then idle", {pass_o, walk_ready_o}, 2'b01);
    end else if (seen_fault) begin
      n0 = log_n;
      walk_valid_i = 1'b1;
      repeat (3) @(negedge clk);
      // R8: sticky, ready low, request ignored
      chk(fault_o && !walk_ready_o, "R8 fault sticky", {fault_o, walk_ready_o}, 2'b10);
      chk(log_n == n0, "R8 no read in fault", log_n, n0);
      walk_valid_i = 1'b0;
      fault_clr_i = 1'b1;
      @(negedge clk);
      fault_clr_i = 1'b0;
      chk(!fault_o && walk_ready_o && fault_code_o == 2'd0, "R8 clear to idle",
          {fault_o, walk_ready_o, fault_code_o}, 4'b0100);
    end
  endtask

  initial begin
    int unused;
    int d;
    int de;
    checks = 0;
    fails = 0;
    unused = $urandom(32'd4711);
    log_n = 0;
    mac_n = 0;
    cur_line = '0;
    cur_bad = 0;
    rst_n = 1'b0;
    walk_valid_i = 1'b0;
    walk_line_i = '0;
    walk_depth_i = '0;
    fault_clr_i = 1'b0;
    root_i = '0;
    for (int k = 0; k < MAXL; k++) begin
      base_tab[k] = 32'h1000_0000 * (k + 1) + $urandom_range(32'hFFFF);
      lvl_base_i[k*AW +: AW] = base_tab[k];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(walk_ready_o && !rd_valid_o && !mac_valid_o && !pass_o && !fault_o && fault_code_o == 0,
        "R1 reset state", {walk_ready_o, rd_valid_o, mac_valid_o, pass_o, fault_o}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(walk_ready_o && !rd_valid_o && !fault_o, "R1 after release",
        {walk_ready_o, rd_valid_o, fault_o}, 3'b100);

    // Directed corners
    run_walk(32'h0001_2345, 1, 0);       // R5 single level, root compare only
    run_walk(32'h0001_2345, 1, 1);       // R7 root mismatch at depth 1
    run_walk(32'hFFFF_FFFF, 6, 0);       // R2 full depth, all-ones line
    run_walk(32'h0ABC_DEF0, 6, 1);       // R6 mismatch at first parent
    run_walk(32'h0ABC_DEF0, 6, 5);       // R6 mismatch at top parent
    run_walk(32'h0ABC_DEF0, 6, 6);       // R7 root mismatch at full depth
    run_walk(32'h1357_9BDF, 0, 0);       // R10 depth 0 acts as 1
    run_walk(32'h1357_9BDF, 7, 0);       // R10 depth 7 acts as 6
    run_walk(32'h0000_0000, 3, 2);       // R6 mid-level

    // Constrained random walks
    for (int n = 0; n < 60; n++) begin
      d = $urandom_range(7);
      de = eff_depth(d);
      if ($urandom_range(2) == 0) run_walk($urandom, d, 0);
      else run_walk($urandom, d, $urandom_range(de, 1));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule